// File: doc/BRIEF.md
# Half-Duplex Collision Retry Tracker

This block follows one frame through the attempts a half-duplex Ethernet transmitter makes to send it. The MAC tells it when an attempt begins, feeds it a byte-time tick that runs from the first preamble byte, and reports collisions, carrier sense, buffer underflow and the successful end of the frame. For each collision the block decides between retrying and giving up. On a retry it runs a truncated binary exponential backoff, using slot counts drawn from an internal LFSR, and then signals that the MAC may try again.

When the frame finishes, either sent or abandoned, the block raises a one-cycle completion strobe. With that strobe it presents a 4-bit collision count and a set of qualified status flags: late collision, excessive collision, no carrier, loss of carrier, underflow, and an error summary. The flags are cleared when a new frame begins. Deferral, jabber detection and the data path sit outside this block.

Top module: `hd_retry_tracker`

## Requirements
- R1: After reset the block is idle: `done`, `retry_go`, every status flag, `err_sum` and `col_count` are 0.
- R2: A collision in an attempt after at least LATE_WINDOW (64) `byte_tick` pulses since that attempt began is a late collision. It ends the frame: `done` rises on the next cycle with `late_col`=1, `excess_col`=0 and `col_count` unchanged, and no retry follows.
- R3: If `underflow` was high in any transmit cycle of the frame, up to and including the collision cycle, a late collision leaves `late_col`=0 and sets `uflow_err`=1.
- R4: A collision before the late window raises `col_count` by one when retries remain. In that case there is no `done`: a backoff starts and ends with a one-cycle `retry_go`.
- R5: The RETRY_LIMIT-th (16th) collision of a frame ends it with `done` and `excess_col`=1. `col_count` then wraps to 0 and is not valid.
- R6: With `cfg_no_retry`=1, the first collision that is not late ends the frame with `done` and `excess_col`=1. `col_count` is then 1.
- R7: After collision n, `retry_go` follows s*SLOT_TICKS+1 cycles after the collision edge, while `byte_tick` is high every cycle. Here s is an LFSR value in 0 to 2^min(n,10)-1.
- R8: `frame_end` during an attempt ends the frame with `done`. `col_count` then equals the number of collisions that frame had.
- R9: `no_carrier` is 1 at a successful end if `crs` was never high during any cycle of the final attempt.
- R10: `lost_carrier` is 1 at a successful end if `crs` went low after having been high within the final attempt. This applies only when the frame had no collision; otherwise it is 0.
- R11: `err_sum` equals the OR of `late_col`, `excess_col`, `no_carrier`, `lost_carrier` and `uflow_err`, and is presented with `done`.
- R12: `done` lasts one cycle. The flags and `col_count` hold until `attempt_start` in the idle state begins a new frame, which clears them at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attempt_start | input | 1 | Begins a frame (idle) or a retry (after `retry_go`) |
| byte_tick | input | 1 | One pulse per byte time on the wire |
| col_det | input | 1 | Collision detected |
| crs | input | 1 | Carrier sense from the PHY |
| underflow | input | 1 | Transmit buffer underflow during the frame |
| frame_end | input | 1 | Attempt finished sending the whole frame |
| cfg_no_retry | input | 1 | Abort on the first collision |
| retry_go | output | 1 | Backoff expired, start the next attempt |
| done | output | 1 | One-cycle frame completion strobe |
| col_count | output | 4 | Collisions seen on this frame |
| late_col | output | 1 | Late collision abort |
| excess_col | output | 1 | Retry limit reached or retry disabled |
| no_carrier | output | 1 | Carrier never seen in the final attempt |
| lost_carrier | output | 1 | Carrier dropped during a collision-free frame |
| uflow_err | output | 1 | Underflow occurred on the frame |
| err_sum | output | 1 | OR of all error flags |

## Verification
The hardest state to reach is the sixteenth collision. Getting there takes fifteen complete backoff-and-retry round trips whose lengths the LFSR chooses, so the bench cannot know them in advance. The bench therefore drives each retry from the observed `retry_go` rather than from a fixed delay. It checks every wait against the 2^min(n,10) slot bound, and uses a short slot length so the long late-stage backoffs stay within the run. The late-window edge is reached by counting exactly 63 and 64 ticks from the attempt start with the tick held high.

// File: rtl/hrt_pkg.sv
package hrt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TX      = 2'd1,
    ST_BACKOFF = 2'd2,
    ST_WAIT    = 2'd3
  } hrt_state_e;
endpackage

// File: rtl/hrt_lfsr.sv
module hrt_lfsr #(
  parameter int W     = 16,
  parameter int OUT_W = 10,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= SEED;
    else     sr <= {sr[W-2:0], ^(sr & TAPS)};
  end

  assign rnd = sr[OUT_W-1:0];

  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
    sr != '0); // R7
endmodule

// File: rtl/hrt_window.sv
module hrt_window #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic count_en,
  output logic late
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)           cnt <= '0;
    else if (count_en && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign late = (cnt == LIM);

  AST_WIN_SAT: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM); // R2
endmodule

// File: rtl/hrt_backoff.sv
module hrt_backoff #(
  parameter int CAP        = 10,
  parameter int SLOT_TICKS = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [CAP-1:0] load_slots,
  input  logic           run,
  input  logic           tick,
  output logic           expired
);
  localparam int TW = $clog2(SLOT_TICKS + 1);
  localparam logic [TW-1:0] T_LAST = TW'(SLOT_TICKS - 1);

  logic [CAP-1:0] slots_left;
  logic [TW-1:0]  tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      slots_left <= '0;
      tcnt       <= '0;
    end else if (load) begin
      slots_left <= load_slots;
      tcnt       <= '0;
    end else if (run && tick && slots_left != '0) begin
      if (tcnt == T_LAST) begin
        tcnt       <= '0;
        slots_left <= slots_left - 1'b1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign expired = (slots_left == '0);

  AST_SLOTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    !load |=> slots_left <= $past(slots_left)); // R7
endmodule

// File: rtl/hd_retry_tracker.sv
module hd_retry_tracker
  import hrt_pkg::*;
#(
  parameter int RETRY_LIMIT  = 16,
  parameter int LATE_WINDOW  = 64,
  parameter int BACKOFF_CAP  = 10,
  parameter int SLOT_TICKS   = 64,
  parameter int LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int CNT_W = $clog2(RETRY_LIMIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             attempt_start,
  input  logic             byte_tick,
  input  logic             col_det,
  input  logic             crs,
  input  logic             underflow,
  input  logic             frame_end,
  input  logic             cfg_no_retry,
  output logic             retry_go,
  output logic             done,
  output logic [CNT_W-1:0] col_count,
  output logic             late_col,
  output logic             excess_col,
  output logic             no_carrier,
  output logic             lost_carrier,
  output logic             uflow_err,
  output logic             err_sum
);
  localparam logic [CNT_W:0] LIMIT_V = (CNT_W+1)'(RETRY_LIMIT);
  localparam logic [CNT_W:0] CAP_V   = (CNT_W+1)'(BACKOFF_CAP);

  hrt_state_e state;

  logic                   crs_seen, lost_seen, uflow_seen;
  logic                   crs_seen_n, lost_n, uflow_n;
  logic [CNT_W:0]         col_inc, kk;
  logic                   hit_limit, win_late, in_tx, begin_try, bo_load, bo_expired;
  logic [BACKOFF_CAP-1:0] rnd, bo_mask, bo_slots;

  assign in_tx      = (state == ST_TX);
  assign begin_try  = attempt_start && (state == ST_IDLE || state == ST_WAIT);
  assign crs_seen_n = crs_seen | crs;
  assign lost_n     = lost_seen | (crs_seen & ~crs);
  assign uflow_n    = uflow_seen | underflow;
  assign col_inc    = {1'b0, col_count} + 1'b1;
  assign hit_limit  = cfg_no_retry || (col_inc >= LIMIT_V);
  assign kk         = (col_inc > CAP_V) ? CAP_V : col_inc;
  assign bo_mask    = ~({BACKOFF_CAP{1'b1}} << kk);
  assign bo_slots   = rnd & bo_mask;
  assign bo_load    = in_tx && col_det && !win_late && !hit_limit;

  hrt_lfsr #(.W(LFSR_W), .OUT_W(BACKOFF_CAP), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED))
    u_lfsr (.clk(clk), .rst(rst), .rnd(rnd));

  hrt_window #(.LIMIT(LATE_WINDOW))
    u_win (.clk(clk), .rst(rst), .clear(begin_try),
           .count_en(in_tx && byte_tick), .late(win_late));

  hrt_backoff #(.CAP(BACKOFF_CAP), .SLOT_TICKS(SLOT_TICKS))
    u_bo (.clk(clk), .rst(rst), .load(bo_load), .load_slots(bo_slots),
          .run(state == ST_BACKOFF), .tick(byte_tick), .expired(bo_expired));

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      crs_seen     <= 1'b0;
      lost_seen    <= 1'b0;
      uflow_seen   <= 1'b0;
      retry_go     <= 1'b0;
      done         <= 1'b0;
      col_count    <= '0;
      late_col     <= 1'b0;
      excess_col   <= 1'b0;
      no_carrier   <= 1'b0;
      lost_carrier <= 1'b0;
      uflow_err    <= 1'b0;
      err_sum      <= 1'b0;
    end else begin
      retry_go <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        ST_IDLE: if (attempt_start) begin
          state        <= ST_TX;
          crs_seen     <= 1'b0;
          lost_seen    <= 1'b0;
          uflow_seen   <= 1'b0;
          col_count    <= '0;
          late_col     <= 1'b0;
          excess_col   <= 1'b0;
          no_carrier   <= 1'b0;
          lost_carrier <= 1'b0;
          uflow_err    <= 1'b0;
          err_sum      <= 1'b0;
        end
        ST_TX: begin
          crs_seen   <= crs_seen_n;
          lost_seen  <= lost_n;
          uflow_seen <= uflow_n;
          if (col_det) begin
            if (win_late) begin
              state     <= ST_IDLE;
              done      <= 1'b1;
              late_col  <= !uflow_n;
              uflow_err <= uflow_n;
              err_sum   <= 1'b1;
            end else if (hit_limit) begin
              state      <= ST_IDLE;
              done       <= 1'b1;
              excess_col <= 1'b1;
              col_count  <= col_inc[CNT_W-1:0];
              uflow_err  <= uflow_n;
              err_sum    <= 1'b1;
            end else begin
              state     <= ST_BACKOFF;
              col_count <= col_inc[CNT_W-1:0];
            end
          end else if (frame_end) begin
            state        <= ST_IDLE;
            done         <= 1'b1;
            no_carrier   <= !crs_seen_n;
            lost_carrier <= lost_n && (col_count == '0);
            uflow_err    <= uflow_n;
            err_sum      <= !crs_seen_n || (lost_n && (col_count == '0)) || uflow_n;
          end
        end
        ST_BACKOFF: if (byte_tick && bo_expired) begin
          state    <= ST_WAIT;
          retry_go <= 1'b1;
        end
        ST_WAIT: if (attempt_start) begin
          state     <= ST_TX;
          crs_seen  <= 1'b0;
          lost_seen <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_LATE_ABORT: assert property (@(posedge clk) disable iff (rst)
    (in_tx && col_det && win_late) |=> (done && !retry_go && !excess_col)); // R2
  AST_NO_RETRY_ABORT: assert property (@(posedge clk) disable iff (rst)
    (in_tx && col_det && !win_late && cfg_no_retry) |=> (done && excess_col)); // R6
  AST_RETRY_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    bo_load |=> !done); // R4
  AST_LOST_NO_COL: assert property (@(posedge clk) disable iff (rst)
    lost_carrier |-> (col_count == '0 && !excess_col && !late_col)); // R10
  AST_ERR_SUM: assert property (@(posedge clk) disable iff (rst)
    done |-> (err_sum == (late_col | excess_col | no_carrier | lost_carrier | uflow_err))); // R11
endmodule

// File: tb/sim_hd_retry_tracker.sv
module sim_hd_retry_tracker;
  localparam int SLOT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic attempt_start = 0, byte_tick = 1, col_det = 0, crs = 0;
  logic underflow = 0, frame_end = 0, cfg_no_retry = 0;
  logic retry_go, done, late_col, excess_col, no_carrier, lost_carrier, uflow_err, err_sum;
  logic [3:0] col_count;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hd_retry_tracker #(.SLOT_TICKS(SLOT)) u0 (
    .clk(clk), .rst(rst), .attempt_start(attempt_start), .byte_tick(byte_tick),
    .col_det(col_det), .crs(crs), .underflow(underflow), .frame_end(frame_end),
    .cfg_no_retry(cfg_no_retry), .retry_go(retry_go), .done(done),
    .col_count(col_count), .late_col(late_col), .excess_col(excess_col),
    .no_carrier(no_carrier), .lost_carrier(lost_carrier), .uflow_err(uflow_err),
    .err_sum(err_sum));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic flags_chk(input string req, input int lc, input int ec,
                           input int nc, input int lo, input int uf);
    chk({req, " late_col"}, late_col, lc);
    chk({req, " excess_col"}, excess_col, ec);
    chk({req, " no_carrier"}, no_carrier, nc);
    chk({req, " lost_carrier"}, lost_carrier, lo);
    chk({req, " uflow_err"}, uflow_err, uf);
    chk({req, " err_sum R11"}, err_sum, (lc | ec | nc | lo | uf));
  endtask

  task automatic start_try();
    attempt_start = 1;
    @(negedge clk);
    attempt_start = 0;
  endtask

  task automatic collide();
    col_det = 1;
    @(negedge clk);
    col_det = 0;
  endtask

  task automatic end_frame();
    frame_end = 1;
    @(negedge clk);
    frame_end = 0;
  endtask

  // collision n just processed: wait for retry_go and check the slot bound
  task automatic await_retry(input int n);
    int c = 0;
    int k = (n > 10) ? 10 : n;
    int bound = ((1 << k) - 1) * SLOT + 1;
    chk("R4 no done on retryable collision", done, 0);
    do begin
      @(negedge clk);
      c++;
    end while (!retry_go && c < 5000);
    chk("R7 retry_go seen", retry_go, 1);
    checks++;
    if (c > bound || ((c - 1) % SLOT) != 0) begin
      errors++;
      $display("FAIL R7 backoff cycles actual %0d expected <= %0d", c, bound);
    end
    @(negedge clk);
    chk("R4 retry_go one cycle", retry_go, 0);
  endtask

  task automatic t_reset();
    chk("R1 done", done, 0);
    chk("R1 retry_go", retry_go, 0);
    chk("R1 col_count", col_count, 0);
    flags_chk("R1", 0, 0, 0, 0, 0);
  endtask

  task automatic t_success();
    crs = 1;
    start_try();
    repeat (20) @(negedge clk);
    end_frame();
    chk("R8 done", done, 1);
    chk("R8 col_count", col_count, 0);
    flags_chk("R8", 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R12 done one cycle", done, 0);
  endtask

  task automatic t_no_carrier();
    crs = 0;
    start_try();
    repeat (10) @(negedge clk);
    end_frame();
    chk("R9 done", done, 1);
    flags_chk("R9", 0, 0, 1, 0, 0);
    repeat (5) @(negedge clk);
    chk("R12 flag held", no_carrier, 1);
    crs = 1;
    start_try();
    chk("R12 cleared at frame start", no_carrier, 0);
    chk("R12 err_sum cleared", err_sum, 0);
    repeat (5) @(negedge clk);
    end_frame();
    flags_chk("R12 clean frame", 0, 0, 0, 0, 0);
  endtask

  task automatic t_lost_carrier();
    crs = 1;
    start_try();
    repeat (5) @(negedge clk);
    crs = 0;
    repeat (5) @(negedge clk);
    end_frame();
    flags_chk("R10 lost no collision", 0, 0, 0, 1, 0);
    // same carrier drop after an earlier collision: not reported
    crs = 1;
    start_try();
    repeat (10) @(negedge clk);
    collide();
    await_retry(1);
    start_try();
    repeat (5) @(negedge clk);
    crs = 0;
    repeat (5) @(negedge clk);
    end_frame();
    chk("R8 col_count after one collision", col_count, 1);
    flags_chk("R10 lost after collision", 0, 0, 0, 0, 0);
    crs = 1;
  endtask

  task automatic t_window_edge();
    crs = 1;
    start_try();
    repeat (63) @(negedge clk);
    collide();
    chk("R2 63 ticks not late", late_col, 0);
    await_retry(1);
    start_try();
    repeat (8) @(negedge clk);
    collide();
    await_retry(2);
    start_try();
    repeat (8) @(negedge clk);
    end_frame();
    chk("R8 col_count two", col_count, 2);
    flags_chk("R8 two collisions", 0, 0, 0, 0, 0);
  endtask

  task automatic t_late();
    crs = 1;
    start_try();
    repeat (64) @(negedge clk);
    collide();
    chk("R2 done", done, 1);
    chk("R2 col_count unchanged", col_count, 0);
    flags_chk("R2", 1, 0, 0, 0, 0);
    repeat (SLOT * 4) @(negedge clk);
    chk("R2 no retry", retry_go, 0);
  endtask

  task automatic t_late_uflow();
    crs = 1;
    start_try();
    repeat (10) @(negedge clk);
    underflow = 1;
    @(negedge clk);
    underflow = 0;
    repeat (60) @(negedge clk);
    collide();
    chk("R3 done", done, 1);
    flags_chk("R3", 0, 0, 0, 0, 1);
  endtask

  task automatic t_no_retry();
    crs = 1;
    cfg_no_retry = 1;
    start_try();
    repeat (5) @(negedge clk);
    collide();
    cfg_no_retry = 0;
    chk("R6 done", done, 1);
    chk("R6 col_count", col_count, 1);
    flags_chk("R6", 0, 1, 0, 0, 0);
  endtask

  task automatic t_excess();
    crs = 1;
    for (int i = 1; i <= 16; i++) begin
      start_try();
      repeat (3) @(negedge clk);
      collide();
      if (i < 16) await_retry(i);
    end
    chk("R5 done", done, 1);
    chk("R5 col_count wraps", col_count, 0);
    flags_chk("R5", 0, 1, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_success();
    t_no_carrier();
    t_lost_carrier();
    t_window_edge();
    t_late();
    t_late_uflow();
    t_no_retry();
    t_excess();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule